// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Sequencer

This block computes M = P^D mod N by steering one external Montgomery multiplier through a start/done handshake. It never multiplies itself. It holds the operand buffers and decides, for each multiplier call, which two buffers are presented and which buffer takes the product. The multiplier returns Mont(a, b) = a·b·2^-W mod N, where W is the operand width.

A run has three phases:

- **Entry.** The base P and the constant 1 are lifted into the Montgomery domain by multiplying each with R² mod N.
- **Loop.** The exponent is scanned one bit per iteration, starting at bit 0. Each iteration squares a running square chain. When the bit is 1 it also multiplies a running product chain by the square value from before that iteration.
- **Exit.** A multiplication of the product chain by 1 brings the result back to the ordinary domain.

The caller gives the number of exponent bits to use. The loop stops after the last of those bits.

Top module: `modexp_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `done`, `busy` and `mulStart` are all 0.
- R2: After `start` in idle, the first multiplier call has operands (A=base, B=R² mod N) and the second has (A=1, B=R² mod N).
- R3: For every exponent bit index i below the clamped length, one squaring call is issued with both operands equal to the square chain value before that iteration. The clamped length is min(expLen, EXP_W).
- R4: Immediately after the squaring for bit i, and only when bit i of the exponent is 1, a call with (A=product chain, B=square value from before bit i) is issued. A 0 bit issues no such call.
- R5: The last call has operands (A=product chain, B=1). Its product appears on `result` when `done` is high, and `done` is high for exactly one cycle. `busy` is low in that cycle.
- R6: The number of multiplier calls in a run is 3 + L + (number of 1 bits among exponent bits 0..L-1), where L is the clamped length. For D=65537 with L=17 this gives 22.
- R7: `mulStart` is a one-cycle pulse. No new call is issued before the multiplier has answered the previous one with `mulDone`.
- R8: A `start` pulse while `busy` is high has no effect on the running computation.
- R9: Base, R² mod N, exponent and length are captured at `start`. Later changes on those inputs during a run do not affect the operands or the result.
- R10: Exponent bits at index L and above are ignored. With L=0 the result is 1 and exactly 3 calls are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| expBits | input | EXP_W | Exponent D, bit 0 consumed first |
| expLen | input | LEN_W | Number of exponent bits to use, clamped to EXP_W |
| baseIn | input | W | Base P (below N) |
| rSquared | input | W | R² mod N, with R = 2^W |
| mulStart | output | 1 | Issue one multiplier call |
| mulOpA | output | W | First multiplier operand |
| mulOpB | output | W | Second multiplier operand |
| mulDone | input | 1 | Multiplier result valid |
| mulResult | input | W | Multiplier product |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | W | P^D mod N |

## Verification
A wrong buffer choice or a stale square value shows up at the multiplier operand ports on the very call that uses it. The bench compares every issued operand pair against a reference call list, so such a fault is caught within one multiplier latency. A wrong bit scan or a wrong length count changes the number of calls and the final product, which are caught at `done`. A broken handshake appears as a second `mulStart` while a call is still outstanding.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [2:0] {
    STEP_ENT_SQ,
    STEP_ENT_CC,
    STEP_SQR,
    STEP_MUL,
    STEP_EXIT
  } step_t;

  typedef struct packed {
    logic  capture;
    logic  snapSq;
    logic  wrSq;
    logic  wrCc;
    logic  wrOut;
    step_t step;
  } dp_ctrl_t;

endpackage

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int EXP_W = 24,
  parameter int LEN_W = $clog2(EXP_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [EXP_W-1:0] expBits,
  input  logic [LEN_W-1:0] expLen,
  input  logic             mulDone,
  output logic             mulStart,
  output logic             busy,
  output logic             done,
  output dp_ctrl_t         ctl
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(EXP_W);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t           state;
  step_t            step;
  logic [EXP_W-1:0] expSh;
  logic [LEN_W-1:0] remain;
  logic             doneR;
  logic             lastBit;
  logic             opDone;

  assign lastBit  = (remain == LEN_W'(1));
  assign opDone   = (state == S_WAIT) && mulDone;
  assign mulStart = (state == S_ISSUE);
  assign busy     = (state != S_IDLE);
  assign done     = doneR;

  always_comb begin
    ctl.capture = (state == S_IDLE) && start;
    ctl.snapSq  = (state == S_ISSUE) && (step == STEP_SQR);
    ctl.wrSq    = opDone && ((step == STEP_ENT_SQ) || (step == STEP_SQR));
    ctl.wrCc    = opDone && ((step == STEP_ENT_CC) || (step == STEP_MUL));
    ctl.wrOut   = opDone && (step == STEP_EXIT);
    ctl.step    = step;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      step   <= STEP_ENT_SQ;
      expSh  <= '0;
      remain <= '0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            expSh  <= expBits;
            remain <= (expLen > MAX_LEN) ? MAX_LEN : expLen;
            step   <= STEP_ENT_SQ;
            state  <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (mulDone) begin
            state <= S_ISSUE;
            case (step)
              STEP_ENT_SQ: step <= STEP_ENT_CC;
              STEP_ENT_CC: step <= (remain == '0) ? STEP_EXIT : STEP_SQR;
              STEP_SQR: begin
                if (expSh[0]) begin
                  step <= STEP_MUL;
                end else begin
                  expSh  <= expSh >> 1;
                  remain <= remain - LEN_W'(1);
                  step   <= lastBit ? STEP_EXIT : STEP_SQR;
                end
              end
              STEP_MUL: begin
                expSh  <= expSh >> 1;
                remain <= remain - LEN_W'(1);
                step   <= lastBit ? STEP_EXIT : STEP_SQR;
              end
              default: begin
                state <= S_IDLE;
                doneR <= 1'b1;
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    mulStart |=> !mulStart);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4
  mul_on_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mulStart && step == STEP_MUL) |-> expSh[0]);

  // R10
  len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    remain <= MAX_LEN);

endmodule

// File: rtl/modexp_dpath.sv
module modexp_dpath
  import modexp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dp_ctrl_t     ctl,
  input  logic [W-1:0] baseIn,
  input  logic [W-1:0] rSquared,
  input  logic [W-1:0] mulResult,
  output logic [W-1:0] mulOpA,
  output logic [W-1:0] mulOpB,
  output logic [W-1:0] result
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] baseReg;
  logic [W-1:0] r2Reg;
  logic [W-1:0] sqReg;
  logic [W-1:0] sqOld;
  logic [W-1:0] ccReg;
  logic [W-1:0] outReg;

  always_comb begin
    case (ctl.step)
      STEP_ENT_SQ: begin mulOpA = baseReg; mulOpB = r2Reg; end
      STEP_ENT_CC: begin mulOpA = ONE;     mulOpB = r2Reg; end
      STEP_SQR:    begin mulOpA = sqReg;   mulOpB = sqReg; end
      STEP_MUL:    begin mulOpA = ccReg;   mulOpB = sqOld; end
      default:     begin mulOpA = ccReg;   mulOpB = ONE;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      r2Reg   <= '0;
      sqReg   <= '0;
      sqOld   <= '0;
      ccReg   <= '0;
      outReg  <= '0;
    end else begin
      if (ctl.capture) begin
        baseReg <= baseIn;
        r2Reg   <= rSquared;
      end
      if (ctl.snapSq) sqOld  <= sqReg;
      if (ctl.wrSq)   sqReg  <= mulResult;
      if (ctl.wrCc)   ccReg  <= mulResult;
      if (ctl.wrOut)  outReg <= mulResult;
    end
  end

  assign result = outReg;

  // R3
  square_ops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrSq && ctl.step == STEP_SQR) |-> (mulOpA == mulOpB));

endmodule

// File: rtl/modexp_seq.sv
module modexp_seq
  import modexp_pkg::*;
#(
  parameter int W     = 16,
  parameter int EXP_W = 24,
  parameter int LEN_W = $clog2(EXP_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [EXP_W-1:0] expBits,
  input  logic [LEN_W-1:0] expLen,
  input  logic [W-1:0]     baseIn,
  input  logic [W-1:0]     rSquared,
  output logic             mulStart,
  output logic [W-1:0]     mulOpA,
  output logic [W-1:0]     mulOpB,
  input  logic             mulDone,
  input  logic [W-1:0]     mulResult,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     result
);

  dp_ctrl_t ctl;

  modexp_ctrl #(.EXP_W(EXP_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .expBits(expBits),
    .expLen(expLen), .mulDone(mulDone), .mulStart(mulStart),
    .busy(busy), .done(done), .ctl(ctl)
  );

  modexp_dpath #(.W(W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseIn(baseIn),
    .rSquared(rSquared), .mulResult(mulResult),
    .mulOpA(mulOpA), .mulOpB(mulOpB), .result(result)
  );

endmodule

// File: tb/modexp_seq_tb.sv
module modexp_seq_tb_top;

  localparam int W     = 16;
  localparam int EXP_W = 24;
  localparam int LEN_W = $clog2(EXP_W + 1);
  localparam int MAXOP = 3 + 2 * EXP_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [EXP_W-1:0] expBits = '0;
  logic [LEN_W-1:0] expLen = '0;
  logic [W-1:0]     baseIn = '0;
  logic [W-1:0]     rSquared = '0;
  logic             mulStart;
  logic [W-1:0]     mulOpA, mulOpB;
  logic             mulDone = 1'b0;
  logic [W-1:0]     mulResult = '0;
  logic             busy, done;
  logic [W-1:0]     result;

  always #10 clk = ~clk;

  modexp_seq #(.W(W), .EXP_W(EXP_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .expBits(expBits),
    .expLen(expLen), .baseIn(baseIn), .rSquared(rSquared),
    .mulStart(mulStart), .mulOpA(mulOpA), .mulOpB(mulOpB),
    .mulDone(mulDone), .mulResult(mulResult), .busy(busy),
    .done(done), .result(result)
  );

  int nChecks = 0;
  int nFails  = 0;
  longint unsigned nCur = 3;
  longint unsigned expA [MAXOP];
  longint unsigned expB [MAXOP];
  string           expTag [MAXOP];
  int              expCnt = 0;
  int              opCnt  = 0;
  int              pendCnt = 0;
  longint unsigned pendRes = 0;
  longint          cycles = 0;

  task automatic check(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned mont(longint unsigned a, longint unsigned b,
                                           longint unsigned n);
    longint unsigned t = a * b;
    for (int i = 0; i < W; i++) begin
      if (t[0]) t = t + n;
      t = t >> 1;
    end
    if (t >= n) t = t - n;
    return t;
  endfunction

  function automatic longint unsigned powmod(longint unsigned p, longint unsigned d,
                                             int len, longint unsigned n);
    longint unsigned r = 1 % n;
    longint unsigned b = p % n;
    for (int i = 0; i < len; i++) begin
      if (d[i]) r = (r * b) % n;
      b = (b * b) % n;
    end
    return r;
  endfunction

  // Multiplier model, driven at negedge
  always @(negedge clk) begin
    cycles++;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        mulDone   = 1'b1;
        mulResult = W'(pendRes);
      end else mulDone = 1'b0;
    end else mulDone = 1'b0;
    if (mulStart) begin
      check(pendCnt == 0, "R7 start while outstanding", pendCnt, 0);
      if (opCnt < expCnt) begin
        check(mulOpA == expA[opCnt], {expTag[opCnt], " opA"}, mulOpA, expA[opCnt]);
        check(mulOpB == expB[opCnt], {expTag[opCnt], " opB"}, mulOpB, expB[opCnt]);
      end else begin
        check(1'b0, "R6 extra call", opCnt, expCnt);
      end
      opCnt++;
      pendRes = mont(mulOpA, mulOpB, nCur);
      pendCnt = 1 + int'($urandom % 4);
    end
  end

  task automatic buildRef(input longint unsigned p, input longint unsigned d,
                          input int len, input longint unsigned r2);
    longint unsigned sq, cc, old;
    expCnt = 0;
    expA[0] = p; expB[0] = r2; expTag[0] = "R2 entry base";
    sq = mont(p, r2, nCur);
    expA[1] = 1; expB[1] = r2; expTag[1] = "R2 entry one";
    cc = mont(1, r2, nCur);
    expCnt = 2;
    for (int i = 0; i < len; i++) begin
      old = sq;
      expA[expCnt] = old; expB[expCnt] = old; expTag[expCnt] = "R3 square";
      expCnt++;
      sq = mont(old, old, nCur);
      if (d[i]) begin
        expA[expCnt] = cc; expB[expCnt] = old; expTag[expCnt] = "R4 multiply";
        expCnt++;
        cc = mont(cc, old, nCur);
      end
    end
    expA[expCnt] = cc; expB[expCnt] = 1; expTag[expCnt] = "R5 exit";
    expCnt++;
  endtask

  task automatic runExp(input longint unsigned n, input longint unsigned p,
                        input longint unsigned d, input int len, input bit disturb);
    longint unsigned r2, em;
    int effLen, wd;
    bit seen;
    nCur   = n;
    r2     = (64'd1 << (2 * W)) % n;
    effLen = (len > EXP_W) ? EXP_W : len;
    buildRef(p, d, effLen, r2);
    em = powmod(p, d, effLen, n);
    @(negedge clk);
    opCnt    = 0;
    baseIn   = W'(p);
    rSquared = W'(r2);
    expBits  = EXP_W'(d);
    expLen   = LEN_W'(len);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (4) @(negedge clk);
      // R8 R9: restart and new inputs during a run
      start    = 1'b1;
      baseIn   = ~baseIn;
      rSquared = rSquared ^ 16'h00F0;
      expBits  = ~expBits;
      expLen   = LEN_W'(EXP_W);
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    wd   = 0;
    while (!seen && wd < 5000) begin
      if (done) seen = 1'b1;
      else begin
        @(negedge clk);
        wd++;
      end
    end
    check(seen, "R5 done reached", wd, 0);
    check(result == W'(em), disturb ? "R9 result unaffected" : "R5 result", result, em);
    check(!busy, "R5 busy low with done", busy, 0);
    check(opCnt == expCnt, effLen == 0 ? "R10 call count" : "R6 call count", opCnt, expCnt);
    @(negedge clk);
    check(!done, "R5 done one cycle", done, 0);
    check(!busy && !mulStart, "R8 idle after run", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(!done && !busy && !mulStart, "R1 in reset", {done, busy, mulStart}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !busy && !mulStart, "R1 after reset", {done, busy, mulStart}, 0);

    // R6: exponent 65537, 17 bits, 22 calls
    runExp(64'd32749, 64'd12345, 64'd65537, 17, 1'b0);
    check(expCnt == 22, "R6 count for 65537", expCnt, 22);
    // R10: zero length gives 1
    runExp(64'd30011, 64'd777, 64'hFFFFFF, 0, 1'b0);
    // R10: upper bits ignored
    runExp(64'd29989, 64'd4242, 64'hFFFFFF, 4, 1'b0);
    // full length, all ones
    runExp(64'd32767, 64'd32766, 64'hFFFFFF, EXP_W, 1'b0);
    // length above EXP_W clamped
    runExp(64'd1021, 64'd5, 64'hA5A5A5, 31, 1'b0);
    // R8 R9: disturbed run
    runExp(64'd25013, 64'd999, 64'h00B3D1, 20, 1'b1);
    // base zero
    runExp(64'd101, 64'd0, 64'h000013, 5, 1'b0);

    for (int k = 0; k < 25; k++) begin
      longint unsigned n = 64'(($urandom % 16383) * 2 + 3);
      longint unsigned p = 64'($urandom) % n;
      longint unsigned d = 64'($urandom % (1 << EXP_W));
      int len = int'($urandom % (EXP_W + 1));
      runExp(n, p, d, len, k % 5 == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule